// File: doc/BRIEF.md
# Supervisory Tone Frequency Classifier

This block watches a squared-up supervisory audio tone that arrives as a one-bit digital signal. It measures how fast that signal toggles over a fixed measurement window, which is timed in cycles of the reference clock. From the result it decides whether the tone sits near 5970 Hz, 6000 Hz or 6030 Hz, or whether no valid tone is present.

When each window closes, the block writes the decision into a 2-bit status output. One cycle later it can raise a single-cycle interrupt, so software can read the fresh code. A mask input blocks the interrupt, but measurement and status updates carry on while it is set.

The tone input passes through a two-flop synchroniser before its rising edges are counted. The count is compared with band limits that are worked out once, at elaboration time, from the window length and the reference clock rate. The block contains no divider.

Top module: `sat_freq_classifier`

## Requirements
- R1: While reset is asserted, and from reset until the first window completes, `sat_status` reads 2'b11 and `sat_irq` is 0.
- R2: A window in which the measured tone frequency is between 5955 Hz and 5984 Hz inclusive gives status code 2'b00.
- R3: A measured frequency between 5985 Hz and 6014 Hz inclusive gives status code 2'b01.
- R4: A measured frequency between 6015 Hz and 6045 Hz inclusive gives status code 2'b10.
- R5: A measured frequency below 5955 Hz, zero included, or above 6045 Hz gives status code 2'b11 (no tone).
- R6: A window lasts exactly GATE_CYCLES reference clock cycles, and windows follow one another with no gap. The measured frequency is the number of rising tone edges in the window multiplied by REF_HZ / GATE_CYCLES. `sat_status` changes only in the cycle after a window ends and holds its value in every other cycle.
- R7: While `irq_mask` is 0, `sat_irq` goes high for exactly one cycle at the end of every window. That cycle is the one after the cycle in which `sat_status` took its new value.
- R8: While `irq_mask` is 1, no interrupt pulse appears, but measurement continues and `sat_status` is still updated at each window end.
- R9: Only rising edges of the tone count, and each input level is sampled on the reference clock. A tone that holds each level for at least one clock cycle gives exactly one count per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_in | input | 1 | Squared-up tone input, asynchronous to clk |
| irq_mask | input | 1 | 1 blocks the end-of-window interrupt |
| sat_status | output | 2 | Band code of the last completed window |
| sat_irq | output | 1 | Single-cycle end-of-window interrupt pulse |

## Verification
A corrupted edge count or a misplaced band limit does not show up right away. It appears as a wrong code on `sat_status` when the current window closes, so it can take up to GATE_CYCLES + 1 cycles to become visible. A window timer that drifts is caught by the distance between successive interrupts. The bench measures that distance exactly against GATE_CYCLES. A faulty interrupt register or mask path shows within two cycles of a window end, as a pulse that is missing, extra or too long. It also shows as a pulse that is not placed exactly one cycle after the status change. The directed stimuli sit on both sides of every band limit, so a limit shifted by a single count changes a code.

// File: rtl/sat_cls_pkg.sv
package sat_cls_pkg;

    typedef enum logic [1:0] {
        TONE_LOW  = 2'b00,
        TONE_MID  = 2'b01,
        TONE_HIGH = 2'b10,
        TONE_NONE = 2'b11
    } tone_code_e;

    typedef struct packed {
        tone_code_e status;
        logic       done;
        logic       irq;
    } cls_state_t;

    // Smallest edge count whose scaled frequency reaches hz.
    function automatic longint unsigned hz_to_edges(
        input longint unsigned hz,
        input longint unsigned gate_cycles,
        input longint unsigned ref_hz
    );
        return (hz * gate_cycles + ref_hz - 64'd1) / ref_hz;
    endfunction

endpackage

// File: rtl/sat_sync_edge.sv
module sat_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_i,
    output logic rise_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = tone_i;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.sync & ~s_q.prev;
endmodule

// File: rtl/sat_gate_timer.sv
module sat_gate_timer #(
    parameter int unsigned GATE_CYCLES = 1000000,
    parameter int unsigned TMR_W       = $clog2(GATE_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    output logic last_o
);
    localparam logic [TMR_W-1:0] LAST_CNT = TMR_W'(GATE_CYCLES - 1);

    logic [TMR_W-1:0] cnt_d, cnt_q;

    assign last_o = (cnt_q == LAST_CNT);

    always_comb begin
        cnt_d = last_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sat_edge_counter.sv
module sat_edge_counter #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             last_i,
    output logic [CNT_W-1:0] total_o
);
    logic [CNT_W-1:0] acc_d, acc_q;

    // Includes an edge arriving in the closing cycle of the window.
    assign total_o = acc_q + CNT_W'(rise_i);

    always_comb begin
        acc_d = last_i ? '0 : total_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/sat_band_decode.sv
module sat_band_decode
    import sat_cls_pkg::*;
#(
    parameter int unsigned     CNT_W  = 20,
    parameter longint unsigned THR_LO = 5955,
    parameter longint unsigned THR_M  = 5985,
    parameter longint unsigned THR_H  = 6015,
    parameter longint unsigned THR_UP = 6046
) (
    input  logic [CNT_W-1:0] count_i,
    output tone_code_e       code_o
);
    logic [63:0] cnt64;
    assign cnt64 = 64'(count_i);

    always_comb begin
        if (cnt64 < THR_LO)      code_o = TONE_NONE;
        else if (cnt64 < THR_M)  code_o = TONE_LOW;
        else if (cnt64 < THR_H)  code_o = TONE_MID;
        else if (cnt64 < THR_UP) code_o = TONE_HIGH;
        else                     code_o = TONE_NONE;
    end
endmodule

// File: rtl/sat_freq_classifier.sv
module sat_freq_classifier
    import sat_cls_pkg::*;
#(
    parameter int unsigned REF_HZ       = 1000000,
    parameter int unsigned GATE_CYCLES  = 1000000,
    parameter int unsigned LOW_MIN_HZ   = 5955,
    parameter int unsigned MID_MIN_HZ   = 5985,
    parameter int unsigned HIGH_MIN_HZ  = 6015,
    parameter int unsigned HIGH_MAX_HZ  = 6045
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_in,
    input  logic       irq_mask,
    output logic [1:0] sat_status,
    output logic       sat_irq
);
    localparam int unsigned MAX_EDGES = GATE_CYCLES / 2 + 1;
    localparam int unsigned CNT_W     = $clog2(MAX_EDGES + 1);
    localparam int unsigned TMR_W     = $clog2(GATE_CYCLES);

    localparam longint unsigned THR_LO = hz_to_edges(64'(LOW_MIN_HZ),      64'(GATE_CYCLES), 64'(REF_HZ));
    localparam longint unsigned THR_M  = hz_to_edges(64'(MID_MIN_HZ),      64'(GATE_CYCLES), 64'(REF_HZ));
    localparam longint unsigned THR_H  = hz_to_edges(64'(HIGH_MIN_HZ),     64'(GATE_CYCLES), 64'(REF_HZ));
    localparam longint unsigned THR_UP = hz_to_edges(64'(HIGH_MAX_HZ + 1), 64'(GATE_CYCLES), 64'(REF_HZ));

    logic             tone_rise;
    logic             win_last;
    logic [CNT_W-1:0] edge_total;
    tone_code_e       band_code;
    cls_state_t       st_d, st_q;

    sat_sync_edge u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tone_i (tone_in),
        .rise_o (tone_rise)
    );

    sat_gate_timer #(
        .GATE_CYCLES (GATE_CYCLES),
        .TMR_W       (TMR_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_o (win_last)
    );

    sat_edge_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (tone_rise),
        .last_i  (win_last),
        .total_o (edge_total)
    );

    sat_band_decode #(
        .CNT_W  (CNT_W),
        .THR_LO (THR_LO),
        .THR_M  (THR_M),
        .THR_H  (THR_H),
        .THR_UP (THR_UP)
    ) u_decode (
        .count_i (edge_total),
        .code_o  (band_code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = win_last;
        if (win_last) st_d.status = band_code;
        st_d.irq  = st_q.done & ~irq_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.status <= TONE_NONE;
            st_q.done   <= 1'b0;
            st_q.irq    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sat_status = st_q.status;
    assign sat_irq    = st_q.irq;
endmodule

// File: rtl/sat_freq_classifier_chk.sv
module sat_freq_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_mask,
    input logic [1:0] sat_status,
    input logic       sat_irq,
    input logic       win_last
);
    // R7: the interrupt never lasts longer than one cycle
    p_irq_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sat_irq |=> !sat_irq);

    // R7: a pulse occurs only two cycles after a window closes
    p_irq_after_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sat_irq |-> $past(win_last, 2));

    // R7: an unmasked window end always produces a pulse
    p_irq_every_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win_last, 2) && !$past(irq_mask)) |-> sat_irq);

    // R8: a set mask blocks the pulse
    p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sat_irq |-> !$past(irq_mask));

    // R6: status moves only right after a window end
    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_last) |-> $stable(sat_status));
endmodule

bind sat_freq_classifier sat_freq_classifier_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_mask   (irq_mask),
    .sat_status (sat_status),
    .sat_irq    (sat_irq),
    .win_last   (win_last)
);

// File: tb/sat_freq_classifier_test.sv
`timescale 1ns/1ps
module sat_freq_classifier_test;
    localparam int unsigned GATE = 12500;
    localparam int unsigned REFR = 12500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_in = 1'b0;
    logic       irq_mask = 1'b0;
    logic [1:0] sat_status;
    logic       sat_irq;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  reported = 1'b0;
    longint cyc = 0;
    longint last_irq_cyc = -1;
    logic [1:0] old_code;

    sat_freq_classifier #(.REF_HZ(REFR), .GATE_CYCLES(GATE)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tone_in    (tone_in),
        .irq_mask   (irq_mask),
        .sat_status (sat_status),
        .sat_irq    (sat_irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected code from frequency in Hz (R2..R5)
    function automatic logic [1:0] band_of(input int hz);
        if (hz >= 5955 && hz <= 5984) return 2'b00;
        if (hz >= 5985 && hz <= 6014) return 2'b01;
        if (hz >= 6015 && hz <= 6045) return 2'b10;
        return 2'b11;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // n full tone periods, one clock high and one clock low each (R9)
    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tone_in = 1'b1;
            @(negedge clk) tone_in = 1'b0;
        end
    endtask

    // Wait for the interrupt and check code, its timing and pulse width
    task automatic wait_irq(input logic [1:0] exp, input string req);
        logic [1:0] h1, h2;
        bit got;
        got = 1'b0;
        h1 = sat_status;
        h2 = sat_status;
        for (int i = 0; i < GATE + 100; i++) begin
            @(negedge clk);
            if (sat_irq) begin
                got = 1'b1;
                break;
            end
            h2 = h1;
            h1 = sat_status;
        end
        check(got, "R7 irq present", got, 1);
        if (got) begin
            check(sat_status == exp, req, sat_status, exp);
            check(h1 == exp, "R7 status updated one cycle before irq", h1, exp);
            check(h2 == old_code, "R6 status held until window end", h2, old_code);
            if (last_irq_cyc >= 0)
                check(cyc - last_irq_cyc == GATE, "R6 window length", cyc - last_irq_cyc, GATE);
            last_irq_cyc = cyc;
            @(negedge clk);
            check(sat_irq == 1'b0, "R7 irq single cycle", sat_irq, 0);
        end
        old_code = exp;
    endtask

    task automatic run_window(input int hz, input string req);
        burst(hz);
        wait_irq(band_of(hz), req);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 195000);
        report();
    end

    initial begin
        int irq_seen;
        int hz;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        check(sat_status == 2'b11, "R1 status in reset", sat_status, 3);
        check(sat_irq == 1'b0, "R1 irq in reset", sat_irq, 0);
        @(negedge clk) rst_n = 1'b1;
        old_code = 2'b11;
        // R1/R5: first window with no tone stays 11, zero count reports no tone
        wait_irq(2'b11, "R5 zero count");

        run_window(5954, "R5 just below lowest band");
        run_window(5955, "R2 lower edge of 5970 band");
        run_window(5984, "R2 upper edge of 5970 band");
        run_window(5985, "R3 lower edge of 6000 band");
        run_window(6014, "R3 upper edge of 6000 band");
        run_window(6015, "R4 lower edge of 6030 band");
        run_window(6045, "R4 upper edge of 6030 band");
        run_window(6046, "R5 just above highest band");

        // R8: masked window still measures, but no pulse
        irq_mask = 1'b1;
        irq_seen = 0;
        burst(6000);
        while (cyc < last_irq_cyc + GATE) begin
            @(negedge clk);
            if (sat_irq) irq_seen++;
        end
        check(irq_seen == 0, "R8 masked irq suppressed", irq_seen, 0);
        check(sat_status == 2'b01, "R8 status updated while masked", sat_status, 1);
        old_code = 2'b01;
        last_irq_cyc = last_irq_cyc + GATE;
        irq_mask = 1'b0;

        // Random frequencies around the bands (R2..R5, R9)
        for (int k = 0; k < 2; k++) begin
            hz = 5940 + int'($urandom % 120);
            run_window(hz, "R9 random frequency classified");
        end
        report();
    end
endmodule